// File: doc/BRIEF.md
# Ethernet Buffer Descriptor Ring Engine

This engine is the DMA side of a network controller. It owns a small table of buffer descriptors, each two 32-bit words long. A host reads and writes the table through a simple word-addressed port. The table holds two rings. The first `txNum` descriptors form the transmit ring, and the remaining descriptors, up to `NDESC`, form the receive ring that follows it. The first word of a descriptor is control and status: a byte length in the upper half-word and ownership, interrupt, wrap, padding and CRC flags in the lower half. The second word is the byte address of the descriptor's data buffer. The buffers themselves sit in a byte-wide memory outside the engine.

On transmit, the engine waits at its current descriptor until the ready flag is set. It then streams the described bytes out on a valid/ready byte interface, clears the flag, records a completion and moves on. On receive, every frame arriving on the byte input goes into the buffer of the current descriptor, provided that descriptor is marked empty. Its length is then written back, the empty flag is cleared and the ring advances. A frame that finds no empty descriptor is dropped, and a frame that is too long is truncated. Completion and error events collect in a write-one-to-clear status word, which a mask word gates onto a single interrupt line.

Top module: `ring_desc_engine`

## Requirements
- R1: After reset the interrupt output and `txValid` are low, both ring positions are at their first descriptor, and the status word reads 0.
- R2: Descriptor d occupies table word 2d (control: length in bits 31:16, ownership in bit 15, interrupt request in bit 14, wrap in bit 13, pad request in bit 12, CRC request in bit 11) and word 2d+1 (buffer byte address). Host word 2·NDESC is the status word and word 2·NDESC+1 is the mask word. Receive descriptor r is table descriptor txNum+r.
- R3: When the current transmit descriptor has bit 15 set and a non-zero length L, exactly L bytes are presented, read from buffer address, buffer address+1, and so on, with `txLast` on the final byte. `txPad` and `txCrc` show bits 12 and 11 of that descriptor, and the byte and flags hold while `txReady` is low.
- R4: On the final transmit handshake the engine clears bit 15 of the control word, leaves all of its other bits as they were, and sets status bits 1:0.
- R5: Transmit descriptors are served strictly in ring order. The engine presents nothing while the current one has bit 15 clear, and a ready descriptor of length 0 is retired (bit 15 cleared, status bits 1:0 set) without presenting a byte.
- R6: After a descriptor with bit 13 set, or after the last descriptor of its ring, that ring's position returns to its first descriptor. Otherwise it moves to the next descriptor.
- R7: A frame arriving while the current receive descriptor has bit 15 set has byte k written to buffer address+k. The control word then becomes: byte count in bits 31:16, bit 15 clear, bits 14:0 unchanged. The receive position then advances.
- R8: A receive completion sets status bit 2 only when bit 14 of that descriptor was set.
- R9: A frame arriving while the current receive descriptor has bit 15 clear is dropped. No buffer byte is written, the descriptor is left unchanged, status bit 4 is set and the receive position stays where it is.
- R10: Bytes of a frame beyond `BUF_BYTES` are discarded, the recorded length is `BUF_BYTES`, and status bit 3 is set.
- R11: Writing the status word clears every bit written as 1 (an event in the same cycle takes precedence). The interrupt output is high exactly when some status bit and its mask bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txNum | input | IDXW | Number of transmit descriptors (static, 1 to NDESC-1) |
| hostWe | input | 1 | Host write strobe |
| hostAddr | input | HAW | Host word address |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Host read data for `hostAddr` (combinational) |
| irq | output | 1 | Masked interrupt |
| txValid | output | 1 | Transmit byte valid |
| txReady | input | 1 | Transmit byte accepted |
| txData | output | 8 | Transmit byte |
| txLast | output | 1 | Final byte of a frame |
| txPad | output | 1 | Pad request of the current frame |
| txCrc | output | 1 | CRC request of the current frame |
| bufRdAddr | output | BUF_AW | Buffer memory read address |
| bufRdData | input | 8 | Buffer memory read data (combinational) |
| rxValid | input | 1 | Receive byte valid |
| rxData | input | 8 | Receive byte |
| rxLast | input | 1 | Final byte of a received frame |
| bufWe | output | 1 | Buffer memory write strobe |
| bufWrAddr | output | BUF_AW | Buffer memory write address |
| bufWrData | output | 8 | Buffer memory write data |

## Verification
The bench builds the engine with six descriptors split three and three, 16-byte buffers and an 8-bit buffer address. With rings only three deep, end-of-ring wrapping is reached after a handful of frames and can be contrasted with an explicit wrap flag set in mid-ring. With a 16-byte buffer limit, one 20-byte frame is enough to exercise truncation and the error flag. The bench also stalls the transmit stream on every third cycle, so the hold behaviour is checked against the expected byte queue throughout.

// File: rtl/ring_pkg.sv
package ring_pkg;

  localparam int CTL_OWN  = 15;
  localparam int CTL_INT  = 14;
  localparam int CTL_WRAP = 13;
  localparam int CTL_PAD  = 12;
  localparam int CTL_CRC  = 11;

  localparam int ST_BITS   = 5;
  localparam int ST_RXDONE = 2;
  localparam int ST_RXERR  = 3;
  localparam int ST_RXOVR  = 4;

  typedef struct packed {
    logic txStep;
    logic txDone;
    logic rxStore;
    logic rxTrunc;
    logic rxDone;
    logic rxOver;
  } ringStrobes_t;

  typedef enum logic [0:0] {T_IDLE, T_SEND} txState_t;
  typedef enum logic [1:0] {R_IDLE, R_RECV, R_DROP} rxState_t;

endpackage

// File: rtl/ring_dp.sv
module ring_dp
  import ring_pkg::*;
#(
  parameter int NDESC     = 8,
  parameter int BUF_BYTES = 1536,
  parameter int BUF_AW    = 16,
  localparam int IDXW  = $clog2(NDESC),
  localparam int WAW   = IDXW + 1,
  localparam int HAW   = IDXW + 2,
  localparam int CNTW  = $clog2(BUF_BYTES + 1),
  localparam int WORDS = 2 * NDESC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IDXW-1:0]   txNum,
  input  logic              hostWe,
  input  logic [HAW-1:0]    hostAddr,
  input  logic [31:0]       hostWdata,
  output logic [31:0]       hostRdata,
  input  ringStrobes_t      stb,
  output logic              txOwn,
  output logic              txLenZero,
  output logic              txLastByte,
  output logic              txPad,
  output logic              txCrc,
  output logic [BUF_AW-1:0] bufRdAddr,
  output logic              rxOwn,
  output logic              rxFull,
  output logic [BUF_AW-1:0] bufWrAddr,
  output logic              irq
);

  logic [31:0]         descMem [WORDS];
  logic [IDXW-1:0]     txIdx, rxIdx, rxAbs;
  logic [IDXW:0]       rxNum;
  logic [15:0]         txCnt, txLen, rxLenNext;
  logic [CNTW-1:0]     rxCnt;
  logic                rxTruncHold;
  logic [ST_BITS-1:0]  intStatus, intMask, stSet, stClr;
  logic [WAW-1:0]      txCtlA, txAdrA, rxCtlA, rxAdrA;
  logic [31:0]         txCtl, txBase, rxCtl, rxBase;
  logic                hostDesc, hostSt, hostMk;
  logic                txRingEnd, rxRingEnd;

  assign rxAbs  = txNum + rxIdx;
  assign rxNum  = (IDXW+1)'(NDESC) - {1'b0, txNum};
  assign txCtlA = {txIdx, 1'b0};
  assign txAdrA = {txIdx, 1'b1};
  assign rxCtlA = {rxAbs, 1'b0};
  assign rxAdrA = {rxAbs, 1'b1};
  assign txCtl  = descMem[txCtlA];
  assign txBase = descMem[txAdrA];
  assign rxCtl  = descMem[rxCtlA];
  assign rxBase = descMem[rxAdrA];

  assign txLen      = txCtl[31:16];
  assign txOwn      = txCtl[CTL_OWN];
  assign txLenZero  = (txLen == 16'd0);
  assign txLastByte = (txCnt == txLen - 16'd1);
  assign txPad      = txCtl[CTL_PAD];
  assign txCrc      = txCtl[CTL_CRC];
  assign bufRdAddr  = BUF_AW'(txBase + 32'(txCnt));

  assign rxOwn      = rxCtl[CTL_OWN];
  assign rxFull     = (rxCnt == CNTW'(BUF_BYTES));
  assign bufWrAddr  = BUF_AW'(rxBase + 32'(rxCnt));
  assign rxLenNext  = 16'(rxCnt) + 16'(stb.rxStore);

  assign txRingEnd  = txCtl[CTL_WRAP] || (txIdx == txNum - 1'b1);
  assign rxRingEnd  = rxCtl[CTL_WRAP] || ({1'b0, rxIdx} == rxNum - 1'b1);

  assign hostDesc = hostAddr < HAW'(WORDS);
  assign hostSt   = hostAddr == HAW'(WORDS);
  assign hostMk   = hostAddr == HAW'(WORDS + 1);

  always_comb begin
    hostRdata = '0;
    if (hostDesc)    hostRdata = descMem[hostAddr[WAW-1:0]];
    else if (hostSt) hostRdata = 32'(intStatus);
    else if (hostMk) hostRdata = 32'(intMask);
  end

  always_comb begin
    stSet = '0;
    if (stb.txDone) stSet[1:0] = 2'b11;
    stSet[ST_RXDONE] = stb.rxDone && rxCtl[CTL_INT];
    stSet[ST_RXERR]  = stb.rxDone && (rxTruncHold || stb.rxTrunc);
    stSet[ST_RXOVR]  = stb.rxOver;
    stClr = (hostWe && hostSt) ? hostWdata[ST_BITS-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) descMem[i] <= '0;
      txIdx       <= '0;
      rxIdx       <= '0;
      txCnt       <= '0;
      rxCnt       <= '0;
      rxTruncHold <= 1'b0;
      intStatus   <= '0;
      intMask     <= '0;
    end else begin
      if (hostWe && hostDesc) descMem[hostAddr[WAW-1:0]] <= hostWdata;
      if (hostWe && hostMk)   intMask <= hostWdata[ST_BITS-1:0];
      if (stb.txDone) begin
        descMem[txCtlA] <= txCtl & ~(32'h1 << CTL_OWN);
        txIdx <= txRingEnd ? '0 : txIdx + 1'b1;
        txCnt <= '0;
      end else if (stb.txStep) begin
        txCnt <= txCnt + 16'd1;
      end
      if (stb.rxDone) begin
        descMem[rxCtlA] <= (rxCtl & 32'h0000_7FFF) | {rxLenNext, 16'h0000};
        rxIdx       <= rxRingEnd ? '0 : rxIdx + 1'b1;
        rxCnt       <= '0;
        rxTruncHold <= 1'b0;
      end else begin
        if (stb.rxStore) rxCnt <= rxCnt + 1'b1;
        if (stb.rxTrunc) rxTruncHold <= 1'b1;
      end
      intStatus <= (intStatus & ~stClr) | stSet;
    end
  end

  assign irq = |(intStatus & intMask);

  assert_over_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.rxOver |=> intStatus[ST_RXOVR]);

  assert_txidx_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    txIdx < txNum);

  assert_rxidx_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    {1'b0, rxIdx} < rxNum);

  assert_rxcnt_cap_R10: assert property (@(posedge clk) disable iff (!rstN)
    rxCnt <= CNTW'(BUF_BYTES));

endmodule

// File: rtl/ring_ctl.sv
module ring_ctl
  import ring_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         txOwn,
  input  logic         txLenZero,
  input  logic         txLastByte,
  input  logic         txReady,
  input  logic         rxValid,
  input  logic         rxLast,
  input  logic         rxOwn,
  input  logic         rxFull,
  output ringStrobes_t stb,
  output logic         txValid,
  output logic         txLast
);

  txState_t txState, txNext;
  rxState_t rxState, rxNext;

  always_comb begin
    stb     = '0;
    txValid = 1'b0;
    txLast  = 1'b0;
    txNext  = txState;
    rxNext  = rxState;

    case (txState)
      T_IDLE: begin
        if (txOwn) begin
          if (txLenZero) stb.txDone = 1'b1;
          else           txNext = T_SEND;
        end
      end
      default: begin
        txValid = 1'b1;
        txLast  = txLastByte;
        if (txReady) begin
          if (txLastByte) begin
            stb.txDone = 1'b1;
            txNext     = T_IDLE;
          end else begin
            stb.txStep = 1'b1;
          end
        end
      end
    endcase

    case (rxState)
      R_IDLE: begin
        if (rxValid) begin
          if (!rxOwn) begin
            stb.rxOver = 1'b1;
            if (!rxLast) rxNext = R_DROP;
          end else begin
            stb.rxStore = 1'b1;
            if (rxLast) stb.rxDone = 1'b1;
            else        rxNext = R_RECV;
          end
        end
      end
      R_RECV: begin
        if (rxValid) begin
          if (rxFull) stb.rxTrunc = 1'b1;
          else        stb.rxStore = 1'b1;
          if (rxLast) begin
            stb.rxDone = 1'b1;
            rxNext     = R_IDLE;
          end
        end
      end
      default: begin
        if (rxValid && rxLast) rxNext = R_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txState <= T_IDLE;
      rxState <= R_IDLE;
    end else begin
      txState <= txNext;
      rxState <= rxNext;
    end
  end

  assert_tx_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid);

  assert_drop_nowrite_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.rxOver |-> !stb.rxStore && !stb.rxDone);

endmodule

// File: rtl/ring_desc_engine.sv
module ring_desc_engine
  import ring_pkg::*;
#(
  parameter int NDESC     = 8,
  parameter int BUF_BYTES = 1536,
  parameter int BUF_AW    = 16,
  localparam int IDXW = $clog2(NDESC),
  localparam int HAW  = IDXW + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IDXW-1:0]   txNum,
  input  logic              hostWe,
  input  logic [HAW-1:0]    hostAddr,
  input  logic [31:0]       hostWdata,
  output logic [31:0]       hostRdata,
  output logic              irq,
  output logic              txValid,
  input  logic              txReady,
  output logic [7:0]        txData,
  output logic              txLast,
  output logic              txPad,
  output logic              txCrc,
  output logic [BUF_AW-1:0] bufRdAddr,
  input  logic [7:0]        bufRdData,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  input  logic              rxLast,
  output logic              bufWe,
  output logic [BUF_AW-1:0] bufWrAddr,
  output logic [7:0]        bufWrData
);

  ringStrobes_t stb;
  logic txOwn, txLenZero, txLastByte, rxOwn, rxFull;

  ring_dp #(.NDESC(NDESC), .BUF_BYTES(BUF_BYTES), .BUF_AW(BUF_AW)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .txNum      (txNum),
    .hostWe     (hostWe),
    .hostAddr   (hostAddr),
    .hostWdata  (hostWdata),
    .hostRdata  (hostRdata),
    .stb        (stb),
    .txOwn      (txOwn),
    .txLenZero  (txLenZero),
    .txLastByte (txLastByte),
    .txPad      (txPad),
    .txCrc      (txCrc),
    .bufRdAddr  (bufRdAddr),
    .rxOwn      (rxOwn),
    .rxFull     (rxFull),
    .bufWrAddr  (bufWrAddr),
    .irq        (irq)
  );

  ring_ctl uCtl (
    .clk        (clk),
    .rstN       (rstN),
    .txOwn      (txOwn),
    .txLenZero  (txLenZero),
    .txLastByte (txLastByte),
    .txReady    (txReady),
    .rxValid    (rxValid),
    .rxLast     (rxLast),
    .rxOwn      (rxOwn),
    .rxFull     (rxFull),
    .stb        (stb),
    .txValid    (txValid),
    .txLast     (txLast)
  );

  assign txData    = bufRdData;
  assign bufWe     = stb.rxStore;
  assign bufWrData = rxData;

  assert_tx_addr_R3: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> $stable(bufRdAddr) && $stable(txLast) && $stable(txPad));

endmodule

// File: tb/sim_ring_desc_engine.sv
`timescale 1ns/1ps
module sim_ring_desc_engine;
  localparam int NDESC = 6, BUF_BYTES = 16, BUF_AW = 8, IDXW = 3, HAW = 5;
  localparam int ST = 12, MK = 13;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, hostWe, irq, txValid, txReady, txLast, txPad, txCrc;
  logic rxValid, rxLast, bufWe;
  logic [IDXW-1:0] txNum;
  logic [HAW-1:0] hostAddr;
  logic [31:0] hostWdata, hostRdata, rd;
  logic [7:0] txData, bufRdData, rxData, bufWrData;
  logic [BUF_AW-1:0] bufRdAddr, bufWrAddr;
  logic [7:0] mem [256];

  int checks = 0, errors = 0;
  int expQ[$];

  ring_desc_engine #(.NDESC(NDESC), .BUF_BYTES(BUF_BYTES), .BUF_AW(BUF_AW)) u0 (
    .clk(clk), .rstN(rstN), .txNum(txNum), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .irq(irq), .txValid(txValid),
    .txReady(txReady), .txData(txData), .txLast(txLast), .txPad(txPad), .txCrc(txCrc),
    .bufRdAddr(bufRdAddr), .bufRdData(bufRdData), .rxValid(rxValid), .rxData(rxData),
    .rxLast(rxLast), .bufWe(bufWe), .bufWrAddr(bufWrAddr), .bufWrData(bufWrData)
  );

  assign bufRdData = mem[bufRdAddr];
  always @(posedge clk) if (bufWe) mem[bufWrAddr] <= bufWrData;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference stream model: every accepted byte is compared with the queue head.
  always @(negedge clk) begin
    if (rstN && txValid && txReady) begin
      int got;
      got = {21'd0, txCrc, txPad, txLast, txData};
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R5 unexpected byte actual=%h expected=none", got);
      end else begin
        int e;
        e = expQ.pop_front();
        if (got != e) begin
          errors++;
          $display("FAIL R3 stream actual=%h expected=%h", got, e);
        end
      end
    end
  end

  task automatic hostWr(input int a, input logic [31:0] d);
    @(posedge clk); #1;
    hostWe = 1'b1; hostAddr = HAW'(a); hostWdata = d;
    @(posedge clk); #1;
    hostWe = 1'b0;
  endtask

  task automatic hostRd(input int a, output logic [31:0] d);
    @(posedge clk); #1;
    hostAddr = HAW'(a);
    @(negedge clk);
    d = hostRdata;
  endtask

  task automatic txPush(input int addr, input int len, input int pad, input int crc);
    for (int k = 0; k < len; k++)
      expQ.push_back((crc << 10) | (pad << 9) | ((k == len - 1) ? 256 : 0) | int'(mem[addr + k]));
  endtask

  task automatic waitTx();
    while (expQ.size() != 0) @(posedge clk);
    repeat (4) @(posedge clk);
  endtask

  task automatic sendFrame(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      rxValid = 1'b1; rxData = 8'(base + i); rxLast = (i == n - 1);
    end
    @(posedge clk); #1;
    rxValid = 1'b0; rxLast = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  initial begin
    int k;
    k = 0;
    txReady = 1'b0;
    wait (rstN === 1'b1);
    forever begin
      @(posedge clk); #1;
      k++;
      txReady = (k % 3 != 2);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = (i < 128) ? 8'(i * 7 + 3) : 8'hEE;
    rstN = 1'b0; hostWe = 1'b0; hostAddr = '0; hostWdata = '0; txNum = 3'd3;
    rxValid = 1'b0; rxLast = 1'b0; rxData = '0;
    repeat (4) @(posedge clk); #1;
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 txValid", 32'(txValid), 0);
    hostRd(ST, rd); chk("R1 status", rd, 0);

    hostWr(MK, 32'h1F);
    hostRd(MK, rd); chk("R2 mask word", rd, 32'h1F);
    // receive ring: descriptors 3..5
    hostWr(7, 32'h80);  hostWr(6, 32'h0000_C000);
    hostWr(9, 32'h90);  hostWr(8, 32'h0000_8000);
    hostWr(11, 32'hB0); hostWr(10, 32'h0000_8000);

    // transmit: zero-length desc1 queued behind desc0 (len 4, pad)
    hostWr(3, 32'h20); hostWr(2, 32'h0000_8000);
    txPush(16, 4, 1, 0);
    hostWr(1, 32'h10); hostWr(0, 32'h0004_9000);
    waitTx();
    hostRd(0, rd); chk("R4 desc0 ctl", rd, 32'h0004_1000);
    hostRd(2, rd); chk("R5 zero-length retired", rd, 32'h0);
    hostRd(ST, rd); chk("R4 tx status", rd, 32'h3);
    chk("R11 irq set", 32'(irq), 1);
    repeat (20) @(posedge clk);
    @(negedge clk); chk("R5 idle at not-ready desc", 32'(txValid), 0);
    hostWr(ST, 32'h3);
    hostRd(ST, rd); chk("R11 w1c", rd, 0);
    chk("R11 irq clear", 32'(irq), 0);

    // end-of-ring wrap, then explicit wrap flag
    txPush(48, 1, 0, 1);
    hostWr(5, 32'h30); hostWr(4, 32'h0001_8800);
    waitTx();
    txPush(64, 2, 0, 0);
    hostWr(1, 32'h40); hostWr(0, 32'h0002_A000);
    waitTx();
    hostRd(0, rd); chk("R6 wrap flag kept", rd, 32'h0002_2000);
    hostWr(3, 32'h50); hostWr(2, 32'h0001_8000);
    repeat (20) @(posedge clk);
    @(negedge clk); chk("R6 returned to first desc", 32'(txValid), 0);
    txPush(96, 1, 0, 0);
    txPush(80, 1, 0, 0);
    hostWr(1, 32'h60); hostWr(0, 32'h0001_8000);
    waitTx();
    hostRd(2, rd); chk("R5 in-order desc1", rd, 32'h0001_0000);
    hostWr(ST, 32'h1F);

    // receive
    sendFrame(5, 8'h11);
    hostRd(6, rd); chk("R7 rx desc3 ctl", rd, 32'h0005_4000);
    chk("R7 rx byte0", 32'(mem[8'h80]), 32'h11);
    chk("R7 rx byte4", 32'(mem[8'h84]), 32'h15);
    hostRd(ST, rd); chk("R8 rx int", rd, 32'h4);
    hostWr(ST, 32'h1F);

    sendFrame(20, 8'h20);
    hostRd(8, rd); chk("R10 truncated length", rd, 32'h0010_0000);
    chk("R10 last kept byte", 32'(mem[8'h9F]), 32'h2F);
    chk("R10 no overrun write", 32'(mem[8'hA0]), 32'hEE);
    hostRd(ST, rd); chk("R8 R10 status", rd, 32'h8);
    hostWr(ST, 32'h1F);

    sendFrame(3, 8'h40);
    hostRd(10, rd); chk("R2 rx desc5 ctl", rd, 32'h0003_0000);
    hostRd(ST, rd); chk("R8 no int request", rd, 0);

    sendFrame(4, 8'h60);
    hostRd(ST, rd); chk("R9 overrun flag", rd, 32'h10);
    chk("R9 buffer untouched", 32'(mem[8'h80]), 32'h11);
    hostRd(6, rd); chk("R9 desc untouched", rd, 32'h0005_4000);

    hostWr(6, 32'h0000_8000);
    sendFrame(2, 8'h70);
    hostRd(6, rd); chk("R6 R9 rx wrap to desc3", rd, 32'h0002_0000);
    chk("R7 rx data after wrap", 32'(mem[8'h80]), 32'h70);

    hostWr(MK, 32'h0F);
    @(negedge clk); chk("R11 masked", 32'(irq), 0);
    hostWr(MK, 32'h10);
    @(negedge clk); chk("R11 unmasked", 32'(irq), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule